// File: doc/BRIEF.md
# Half/Full Duplex Ethernet Transmit MAC

This block turns frames held in a byte-wide, FIFO-style source into a nibble stream on a 4-bit media-independent transmit interface. One nibble leaves per clock, so a clock is four bit times. The block generates the preamble and start delimiter itself. When the source asks for it, the block zero-pads short frames and appends a CRC-32 frame check sequence. It also enforces the inter-frame gap between transmissions.

In half duplex the block follows CSMA/CD. It holds off a new transmission while carrier sense is high. A collision during transmission replaces frame data with a jam pattern and rewinds the source to the first byte of the frame. The block then waits a randomly chosen number of slots (truncated binary exponential backoff, driven by an LFSR) before it retries. After too many failed attempts it drops the frame and reports this with a pulse. In full duplex the carrier-sense and collision inputs are ignored completely.

Top module: `eth_tx_mac`

## Requirements
- R1: Every transmission starts with PRE_NIBBLES-1 nibbles of 4'h5 followed by one nibble 4'hD, with mii_tx_en high throughout; none of it comes from the source.
- R2: Each payload byte is sent as two nibbles, bits [3:0] first and then bits [7:4], and src_pop pulses on the cycle of the second nibble.
- R3: When the frame's pad option is set and the payload is shorter than MIN_FRAME_BYTES, zero bytes follow it up to MIN_FRAME_BYTES. With the option clear, no padding is sent.
- R4: When the frame's FCS option is set, 8 nibbles follow the payload and pad. They hold the inverted reflected CRC-32 (poly 0xEDB88320 reflected, start 0xFFFFFFFF) over payload and pad, least significant nibble first. With the option clear, the frame ends after payload and pad.
- R5: Between any two transmissions mii_tx_en stays low for at least IFG_NIBBLES cycles (96 bit times by default).
- R6: In half duplex, no transmission starts while mii_crs is high; a waiting frame starts once it falls.
- R7: In half duplex, mii_col high during a transmission ends the frame data. JAM_NIBBLES nibbles of 4'h5 follow, src_rewind pulses without a pop, and the next attempt resends the frame from its first byte.
- R8: After the n-th collision of a frame, the retry starts no later than IFG_NIBBLES + (2^min(n,BO_LIMIT) - 1) * SLOT_NIBBLES + 2 idle cycles after the jam.
- R9: When the MAX_ATTEMPTS-th attempt collides, the frame is dropped after its jam. frame_drop pulses once, no further attempt is made, and the next frame in the source is sent.
- R10: In full duplex, mii_crs and mii_col have no effect: frames are sent whole and src_rewind never pulses.
- R11: During reset mii_tx_en, mii_txd, src_pop, src_rewind, frame_done and frame_drop are all 0.
- R12: frame_done pulses once, on the first idle cycle after each frame that was sent without collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1: full duplex, carrier sense and collision ignored |
| src_avail | input | 1 | A frame is present at the source |
| src_data | input | 8 | Current byte of the frame |
| src_last | input | 1 | Current byte is the last payload byte |
| src_pad_en | input | 1 | Pad this frame to the minimum length |
| src_fcs_en | input | 1 | Append a frame check sequence to this frame |
| src_pop | output | 1 | Current byte consumed, advance |
| src_rewind | output | 1 | Return the source to the first byte of the frame |
| mii_txd | output | 4 | Transmit nibble |
| mii_tx_en | output | 1 | Transmit enable |
| mii_crs | input | 1 | Carrier sense |
| mii_col | input | 1 | Collision detect |
| frame_done | output | 1 | Frame sent successfully (pulse) |
| frame_drop | output | 1 | Frame dropped after excessive collisions (pulse) |

## Verification
The bench keeps the default framing values: a 16-nibble preamble, a 60-byte minimum, an 8-nibble jam, a 24-nibble gap, 16 attempts and a backoff exponent cap of 10. It shrinks SLOT_NIBBLES to 2. With that short slot, a frame can collide on all sixteen attempts, including those with the largest backoff windows, and the run stays short. The drop path and the capped backoff bound can therefore both be checked. Frame lengths straddle the 60-byte pad boundary, and the pad and FCS options appear in all combinations.

// File: rtl/eth_tx_mac_pkg.sv
package eth_tx_mac_pkg;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_PRE,
      TX_DATA,
      TX_PAD,
      TX_FCS,
      TX_JAM,
      TX_BACKOFF
   } tx_state_e;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [3:0]  NIB_PREAMBLE  = 4'h5;
   localparam logic [3:0]  NIB_SFD       = 4'hD;
   localparam logic [3:0]  NIB_JAM       = 4'h5;
   localparam int          FCS_NIBBLES   = 8;

   // advance a reflected CRC-32 by four data bits, least significant first
   function automatic logic [31:0] crc_step4(input logic [31:0] c, input logic [3:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 4; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
   import eth_tx_mac_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init,
   input  logic       adv,
   input  logic       shift,
   input  logic [3:0] nib,
   output logic [3:0] fcs_nib
);

   logic [31:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= '1;
      else if (init)  crc_q <= '1;
      else if (adv)   crc_q <= crc_step4(crc_q, nib);
      else if (shift) crc_q <= {4'hF, crc_q[31:4]};
   end

   assign fcs_nib = ~crc_q[3:0];

endmodule

// File: rtl/eth_tx_lfsr.sv
module eth_tx_lfsr #(
   parameter int          W     = 16,
   parameter int          OUT_W = 10,
   parameter logic [31:0] SEED  = 32'h0000_ACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] q
);

   localparam logic [W-1:0] TAPS = (W == 16) ? W'(32'h0000_B400) : W'(32'h8020_0003);
   localparam logic [W-1:0] SEED_W = W'(SEED);

   generate
      if (!(W == 16 || W == 32)) begin : g_bad_width
         $error("eth_tx_lfsr: W must be 16 or 32");
      end
      if (OUT_W > W || OUT_W < 1) begin : g_bad_out
         $error("eth_tx_lfsr: OUT_W must lie in 1..W");
      end
      if (SEED_W == '0) begin : g_bad_seed
         $error("eth_tx_lfsr: seed must be nonzero");
      end
   endgenerate

   logic [W-1:0] st_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     st_q <= SEED_W;
      else if (st_q[0]) st_q <= (st_q >> 1) ^ TAPS;
      else            st_q <= st_q >> 1;
   end

   generate
      if (OUT_W == W) begin : g_full
         assign q = st_q;
      end else begin : g_part
         logic unused_hi;
         assign unused_hi = ^st_q[W-1:OUT_W];
         assign q = st_q[OUT_W-1:0] ^ {OUT_W{unused_hi & 1'b0}};
      end
   endgenerate

endmodule

// File: rtl/eth_tx_backoff.sv
module eth_tx_backoff #(
   parameter int SLOT_NIBBLES = 128,
   parameter int BO_LIMIT     = 10,
   parameter int ATT_W        = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [ATT_W-1:0]    attempt,
   input  logic [BO_LIMIT-1:0] rnd,
   output logic                busy
);

   localparam int TICK_W = (SLOT_NIBBLES > 1) ? $clog2(SLOT_NIBBLES) : 1;
   localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_NIBBLES - 1);

   generate
      if (SLOT_NIBBLES < 1) begin : g_bad_slot
         $error("eth_tx_backoff: SLOT_NIBBLES must be at least 1");
      end
   endgenerate

   logic [BO_LIMIT-1:0] mask;
   logic [BO_LIMIT-1:0] slots_q;
   logic [TICK_W-1:0]   tick_q;

   // mask keeps min(attempt, BO_LIMIT) low bits of the random draw
   always_comb begin
      for (int i = 0; i < BO_LIMIT; i++) mask[i] = (int'(attempt) > i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slots_q <= '0;
         tick_q  <= '0;
      end else if (load) begin
         slots_q <= rnd & mask;
         tick_q  <= '0;
      end else if (slots_q != '0) begin
         if (tick_q == TICK_LAST) begin
            tick_q  <= '0;
            slots_q <= slots_q - 1'b1;
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end

   assign busy = (slots_q != '0);

endmodule

// File: rtl/eth_tx_mac.sv
module eth_tx_mac
   import eth_tx_mac_pkg::*;
#(
   parameter int          MIN_FRAME_BYTES = 60,
   parameter int          PRE_NIBBLES     = 16,
   parameter int          IFG_NIBBLES     = 24,
   parameter int          JAM_NIBBLES     = 8,
   parameter int          SLOT_NIBBLES    = 128,
   parameter int          BO_LIMIT        = 10,
   parameter int          MAX_ATTEMPTS    = 16,
   parameter int          LFSR_W          = 16,
   parameter logic [31:0] LFSR_SEED       = 32'h0000_ACE1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       full_duplex,
   input  logic       src_avail,
   input  logic [7:0] src_data,
   input  logic       src_last,
   input  logic       src_pad_en,
   input  logic       src_fcs_en,
   output logic       src_pop,
   output logic       src_rewind,
   output logic [3:0] mii_txd,
   output logic       mii_tx_en,
   input  logic       mii_crs,
   input  logic       mii_col,
   output logic       frame_done,
   output logic       frame_drop
);

   localparam int NCNT_A   = (PRE_NIBBLES > JAM_NIBBLES) ? PRE_NIBBLES : JAM_NIBBLES;
   localparam int NCNT_TOP = (NCNT_A > FCS_NIBBLES) ? NCNT_A : FCS_NIBBLES;
   localparam int NCNT_W   = $clog2(NCNT_TOP + 1);
   localparam int BCNT_W   = $clog2(MIN_FRAME_BYTES + 1);
   localparam int IFG_W    = $clog2(IFG_NIBBLES + 1);
   localparam int ATT_W    = $clog2(MAX_ATTEMPTS + 1);

   localparam logic [NCNT_W-1:0] PRE_LAST = NCNT_W'(PRE_NIBBLES - 1);
   localparam logic [NCNT_W-1:0] JAM_LAST = NCNT_W'(JAM_NIBBLES - 1);
   localparam logic [NCNT_W-1:0] FCS_LAST = NCNT_W'(FCS_NIBBLES - 1);
   localparam logic [BCNT_W-1:0] MIN_B    = BCNT_W'(MIN_FRAME_BYTES);
   localparam logic [IFG_W-1:0]  IFG_LOAD = IFG_W'(IFG_NIBBLES - 1);
   localparam logic [ATT_W-1:0]  ATT_MAX  = ATT_W'(MAX_ATTEMPTS);

   generate
      if (PRE_NIBBLES < 2) begin : g_bad_pre
         $error("eth_tx_mac: PRE_NIBBLES must be at least 2");
      end
      if (MIN_FRAME_BYTES < 1) begin : g_bad_min
         $error("eth_tx_mac: MIN_FRAME_BYTES must be at least 1");
      end
      if (IFG_NIBBLES < 1 || JAM_NIBBLES < 1) begin : g_bad_gap
         $error("eth_tx_mac: IFG_NIBBLES and JAM_NIBBLES must be at least 1");
      end
      if (MAX_ATTEMPTS < 1) begin : g_bad_att
         $error("eth_tx_mac: MAX_ATTEMPTS must be at least 1");
      end
      if (BO_LIMIT < 1 || LFSR_W < BO_LIMIT) begin : g_bad_bo
         $error("eth_tx_mac: BO_LIMIT must lie in 1..LFSR_W");
      end
   endgenerate

   tx_state_e         state_q, state_d;
   logic [NCNT_W-1:0] ncnt_q, ncnt_d;
   logic              half_q, half_d;
   logic [BCNT_W-1:0] bcnt_q, bcnt_d, bcnt_inc;
   logic [ATT_W-1:0]  att_q, att_d;
   logic              pad_q, pad_d;
   logic              fcs_q, fcs_d;
   logic [IFG_W-1:0]  ifg_q;
   logic              done_q, done_d;
   logic              drop_q, drop_d;

   logic              tx_active, col_hit, deferring, start;
   logic              crc_init, bo_load, bo_busy;
   logic [3:0]        fcs_nib;
   logic [BO_LIMIT-1:0] rnd;

   // ---------------------------------------------------------------
   // Medium access qualifiers
   // ---------------------------------------------------------------
   assign tx_active = (state_q == TX_PRE) || (state_q == TX_DATA) ||
                      (state_q == TX_PAD) || (state_q == TX_FCS);
   assign col_hit   = !full_duplex && mii_col && tx_active;
   assign deferring = !full_duplex && mii_crs;
   assign start     = (state_q == TX_IDLE) && src_avail && (ifg_q == '0) && !deferring;
   assign bcnt_inc  = (bcnt_q < MIN_B) ? bcnt_q + 1'b1 : MIN_B;

   // ---------------------------------------------------------------
   // Nibble output path
   // ---------------------------------------------------------------
   always_comb begin
      mii_txd = 4'h0;
      unique case (state_q)
         TX_PRE:  mii_txd = (ncnt_q == PRE_LAST) ? NIB_SFD : NIB_PREAMBLE;
         TX_DATA: mii_txd = half_q ? src_data[7:4] : src_data[3:0];
         TX_PAD:  mii_txd = 4'h0;
         TX_FCS:  mii_txd = fcs_nib;
         TX_JAM:  mii_txd = NIB_JAM;
         default: mii_txd = 4'h0;
      endcase
   end

   assign mii_tx_en  = tx_active || (state_q == TX_JAM);
   assign src_pop    = (state_q == TX_DATA) && half_q && !col_hit;
   assign src_rewind = col_hit;
   assign frame_done = done_q;
   assign frame_drop = drop_q;

   // ---------------------------------------------------------------
   // Sequencer
   // ---------------------------------------------------------------
   always_comb begin
      state_d  = state_q;
      ncnt_d   = ncnt_q;
      half_d   = half_q;
      bcnt_d   = bcnt_q;
      att_d    = att_q;
      pad_d    = pad_q;
      fcs_d    = fcs_q;
      done_d   = 1'b0;
      drop_d   = 1'b0;
      bo_load  = 1'b0;
      crc_init = 1'b0;
      unique case (state_q)
         TX_IDLE: begin
            if (start) begin
               state_d  = TX_PRE;
               ncnt_d   = '0;
               half_d   = 1'b0;
               bcnt_d   = '0;
               pad_d    = src_pad_en;
               fcs_d    = src_fcs_en;
               crc_init = 1'b1;
            end
         end
         TX_PRE: begin
            if (ncnt_q == PRE_LAST) begin
               state_d = TX_DATA;
               ncnt_d  = '0;
            end else begin
               ncnt_d = ncnt_q + 1'b1;
            end
         end
         TX_DATA: begin
            half_d = !half_q;
            if (half_q) begin
               bcnt_d = bcnt_inc;
               if (src_last) begin
                  if (pad_q && bcnt_inc < MIN_B) begin
                     state_d = TX_PAD;
                  end else if (fcs_q) begin
                     state_d = TX_FCS;
                     ncnt_d  = '0;
                  end else begin
                     state_d = TX_IDLE;
                     att_d   = '0;
                     done_d  = 1'b1;
                  end
               end
            end
         end
         TX_PAD: begin
            half_d = !half_q;
            if (half_q) begin
               bcnt_d = bcnt_inc;
               if (bcnt_inc >= MIN_B) begin
                  if (fcs_q) begin
                     state_d = TX_FCS;
                     ncnt_d  = '0;
                  end else begin
                     state_d = TX_IDLE;
                     att_d   = '0;
                     done_d  = 1'b1;
                  end
               end
            end
         end
         TX_FCS: begin
            if (ncnt_q == FCS_LAST) begin
               state_d = TX_IDLE;
               att_d   = '0;
               done_d  = 1'b1;
            end else begin
               ncnt_d = ncnt_q + 1'b1;
            end
         end
         TX_JAM: begin
            if (ncnt_q == JAM_LAST) begin
               if (att_q >= ATT_MAX) begin
                  state_d = TX_IDLE;
                  att_d   = '0;
                  drop_d  = 1'b1;
               end else begin
                  state_d = TX_BACKOFF;
                  bo_load = 1'b1;
               end
            end else begin
               ncnt_d = ncnt_q + 1'b1;
            end
         end
         TX_BACKOFF: begin
            if (!bo_busy) state_d = TX_IDLE;
         end
         default: state_d = TX_IDLE;
      endcase
      if (col_hit) begin
         state_d = TX_JAM;
         ncnt_d  = '0;
         att_d   = att_q + 1'b1;
         done_d  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         ncnt_q  <= '0;
         half_q  <= 1'b0;
         bcnt_q  <= '0;
         att_q   <= '0;
         pad_q   <= 1'b0;
         fcs_q   <= 1'b0;
         done_q  <= 1'b0;
         drop_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         ncnt_q  <= ncnt_d;
         half_q  <= half_d;
         bcnt_q  <= bcnt_d;
         att_q   <= att_d;
         pad_q   <= pad_d;
         fcs_q   <= fcs_d;
         done_q  <= done_d;
         drop_q  <= drop_d;
      end
   end

   // inter-frame gap: held at its load value while transmitting
   always_ff @(posedge clk) begin
      if (!rst_n)          ifg_q <= '0;
      else if (mii_tx_en)  ifg_q <= IFG_LOAD;
      else if (ifg_q != '0) ifg_q <= ifg_q - 1'b1;
   end

   // ---------------------------------------------------------------
   // Sub-blocks
   // ---------------------------------------------------------------
   eth_tx_crc u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .init    (crc_init),
      .adv     (((state_q == TX_DATA) || (state_q == TX_PAD)) && !col_hit),
      .shift   ((state_q == TX_FCS) && !col_hit),
      .nib     (mii_txd),
      .fcs_nib (fcs_nib)
   );

   eth_tx_lfsr #(
      .W     (LFSR_W),
      .OUT_W (BO_LIMIT),
      .SEED  (LFSR_SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .q     (rnd)
   );

   eth_tx_backoff #(
      .SLOT_NIBBLES (SLOT_NIBBLES),
      .BO_LIMIT     (BO_LIMIT),
      .ATT_W        (ATT_W)
   ) u_backoff (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (bo_load),
      .attempt (att_q),
      .rnd     (rnd),
      .busy    (bo_busy)
   );

endmodule

// File: rtl/eth_tx_mac_chk.sv
module eth_tx_mac_chk #(
   parameter int IFG_NIBBLES = 24
) (
   input logic clk,
   input logic rst_n,
   input logic full_duplex,
   input logic mii_crs,
   input logic mii_tx_en,
   input logic src_pop,
   input logic src_rewind,
   input logic frame_done,
   input logic frame_drop
);

   logic [15:0] idle_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 idle_q <= 16'(IFG_NIBBLES);
      else if (mii_tx_en)         idle_q <= '0;
      else if (idle_q != 16'hFFFF) idle_q <= idle_q + 1'b1;
   end

   AST_POP_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
      src_pop |-> mii_tx_en);                                           // R2
   AST_GAP_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mii_tx_en) |-> (idle_q >= 16'(IFG_NIBBLES)));                // R5
   AST_DEFER_ON_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_duplex && mii_crs && !mii_tx_en) |=> !mii_tx_en);           // R6
   AST_REWIND_THEN_JAM: assert property (@(posedge clk) disable iff (!rst_n)
      src_rewind |=> mii_tx_en);                                        // R7
   AST_NO_POP_ON_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      !(src_pop && src_rewind));                                        // R7
   AST_DROP_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop |-> (!mii_tx_en && $past(mii_tx_en)));                  // R9
   AST_FULL_DUPLEX_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      full_duplex |-> !src_rewind);                                     // R10
   AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (!mii_tx_en && $past(mii_tx_en)));                  // R12

endmodule

bind eth_tx_mac eth_tx_mac_chk #(.IFG_NIBBLES(IFG_NIBBLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .full_duplex (full_duplex),
   .mii_crs     (mii_crs),
   .mii_tx_en   (mii_tx_en),
   .src_pop     (src_pop),
   .src_rewind  (src_rewind),
   .frame_done  (frame_done),
   .frame_drop  (frame_drop)
);

// File: tb/eth_tx_mac_tb.sv
`timescale 1ns/1ps
module eth_tx_mac_tb;

   localparam int MINB = 60;
   localparam int PRE  = 16;
   localparam int IFG  = 24;
   localparam int JAM  = 8;
   localparam int SLOT = 2;
   localparam int BOL  = 10;
   localparam int MAXA = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic full_duplex = 1'b1;
   logic src_avail, src_last, src_pad_en, src_fcs_en, src_pop, src_rewind;
   logic [7:0] src_data;
   logic [3:0] mii_txd;
   logic mii_tx_en, frame_done, frame_drop;
   logic mii_crs = 1'b0;
   logic mii_col = 1'b0;

   always #4 clk = ~clk;

   eth_tx_mac #(
      .MIN_FRAME_BYTES (MINB), .PRE_NIBBLES (PRE), .IFG_NIBBLES (IFG),
      .JAM_NIBBLES (JAM), .SLOT_NIBBLES (SLOT), .BO_LIMIT (BOL),
      .MAX_ATTEMPTS (MAXA)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .full_duplex (full_duplex),
      .src_avail (src_avail), .src_data (src_data), .src_last (src_last),
      .src_pad_en (src_pad_en), .src_fcs_en (src_fcs_en),
      .src_pop (src_pop), .src_rewind (src_rewind),
      .mii_txd (mii_txd), .mii_tx_en (mii_tx_en),
      .mii_crs (mii_crs), .mii_col (mii_col),
      .frame_done (frame_done), .frame_drop (frame_drop)
   );

   // ---------------- frame source model ----------------
   logic [7:0] fr_mem [0:31][0:127];
   int         fr_len [0:31];
   bit         fr_pad [0:31];
   bit         fr_fcs [0:31];
   int nfr = 0;
   int cur = 0;
   int idx = 0;

   always_comb begin
      src_avail  = (cur < nfr);
      src_data   = (cur < 32 && idx < 128) ? fr_mem[cur][idx] : 8'h00;
      src_last   = (cur < 32) ? (idx == fr_len[cur] - 1) : 1'b0;
      src_pad_en = (cur < 32) ? fr_pad[cur] : 1'b0;
      src_fcs_en = (cur < 32) ? fr_fcs[cur] : 1'b0;
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (frame_done || frame_drop) begin cur <= cur + 1; idx <= 0; end
         else if (src_rewind)          idx <= 0;
         else if (src_pop)             idx <= idx + 1;
      end
   end

   // ---------------- line monitor ----------------
   logic [3:0] cap [0:1023];
   logic [3:0] bur [0:1023];
   int cap_len = 0, bur_len = 0, bur_gap = 0, cur_gap = 0, idle_run = 1000;
   int n_bursts = 0, n_done = 0, n_drop = 0, n_rew = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mii_tx_en) begin
            if (cap_len == 0) cur_gap = idle_run;
            if (cap_len < 1024) cap[cap_len] = mii_txd;
            cap_len++;
            idle_run = 0;
         end else begin
            if (cap_len > 0) begin
               for (int i = 0; i < cap_len && i < 1024; i++) bur[i] = cap[i];
               bur_len = cap_len; bur_gap = cur_gap; cap_len = 0; n_bursts++;
            end
            idle_run++;
         end
         if (frame_done) n_done++;
         if (frame_drop) n_drop++;
         if (src_rewind) n_rew++;
      end
   end

   // ---------------- checking helpers ----------------
   int checks = 0, errors = 0;
   logic [3:0] expn [0:1023];

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int build_exp(input int f);
      int n = 0;
      logic [31:0] crc = 32'hFFFF_FFFF;
      int total;
      logic [7:0] b;
      for (int i = 0; i < PRE - 1; i++) begin expn[n] = 4'h5; n++; end
      expn[n] = 4'hD; n++;
      total = (fr_pad[f] && fr_len[f] < MINB) ? MINB : fr_len[f];
      for (int i = 0; i < total; i++) begin
         b = (i < fr_len[f]) ? fr_mem[f][i] : 8'h00;
         for (int k = 0; k < 8; k++) begin
            if (crc[0] ^ b[k]) crc = (crc >> 1) ^ 32'hEDB8_8320;
            else               crc = crc >> 1;
         end
         expn[n] = b[3:0]; n++;
         expn[n] = b[7:4]; n++;
      end
      if (fr_fcs[f]) begin
         crc = ~crc;
         for (int i = 0; i < 8; i++) begin expn[n] = crc[4*i +: 4]; n++; end
      end
      return n;
   endfunction

   task automatic cmp_frame(input int f, input string req);
      int n = build_exp(f);
      int bad = -1;
      chk(bur_len == n, req, "burst length", bur_len, n);
      for (int i = 0; i < n && i < bur_len; i++)
         if (bad < 0 && bur[i] !== expn[i]) bad = i;
      if (bad >= 0) chk(1'b0, req, $sformatf("nibble %0d", bad), int'(bur[bad]), int'(expn[bad]));
      else          chk(1'b1, req, "nibbles", 0, 0);
   endtask

   task automatic add_frame(input int len, input bit pad, input bit fcs);
      fr_len[nfr] = len; fr_pad[nfr] = pad; fr_fcs[nfr] = fcs;
      for (int i = 0; i < 128; i++) fr_mem[nfr][i] = 8'($urandom_range(0, 255));
      nfr = nfr + 1;
   endtask

   task automatic wait_burst();
      int n0 = n_bursts;
      while (n_bursts == n0) @(negedge clk);
      #1;
   endtask

   task automatic hit_col(input int at);
      do begin @(negedge clk); #1; end while (!(mii_tx_en && cap_len == at));
      mii_col = 1'b1;
      @(negedge clk); #1;
      mii_col = 1'b0;
   endtask

   function automatic int bo_bound(input int k);
      int e = (k < BOL) ? k : BOL;
      return IFG + ((1 << e) - 1) * SLOT + 2;
   endfunction

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      int f, d0, rw0;
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(mii_tx_en == 0 && mii_txd == 0, "R11", "tx idle in reset", int'(mii_tx_en), 0);
      chk(src_pop == 0 && src_rewind == 0 && frame_done == 0 && frame_drop == 0,
          "R11", "strobes in reset", int'(src_pop), 0);
      rst_n = 1'b1;

      // directed frames around the pad boundary, full duplex
      add_frame(59, 1, 1); wait_burst(); cmp_frame(0, "R3");
      chk(bur_len == PRE + 2*MINB + 8, "R3", "59B padded length", bur_len, PRE + 2*MINB + 8);
      add_frame(60, 1, 1); wait_burst(); cmp_frame(1, "R4");
      add_frame(1, 0, 0);  wait_burst(); cmp_frame(2, "R1");
      chk(bur_len == PRE + 2, "R3", "no pad when disabled", bur_len, PRE + 2);
      add_frame(10, 1, 0); wait_burst(); cmp_frame(3, "R3");
      add_frame(64, 0, 1); wait_burst(); cmp_frame(4, "R4");
      repeat (3) @(negedge clk);
      chk(n_done == 5, "R12", "done pulses", n_done, 5);

      // random frames, queued back to back
      for (int i = 0; i < 4; i++)
         add_frame($urandom_range(1, 100), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      for (int i = 5; i < 9; i++) begin
         wait_burst(); cmp_frame(i, "R2");
         chk(bur_gap >= IFG, "R5", "inter-frame gap", bur_gap, IFG);
      end
      repeat (3) @(negedge clk);
      chk(n_done == 9, "R12", "done pulses after burst", n_done, 9);

      // full duplex ignores carrier and collision
      rw0 = n_rew;
      mii_crs = 1'b1; mii_col = 1'b1;
      add_frame(30, 1, 1); wait_burst(); cmp_frame(9, "R10");
      chk(n_rew == rw0, "R10", "no rewind in full duplex", n_rew - rw0, 0);
      mii_crs = 1'b0; mii_col = 1'b0;
      repeat (30) @(negedge clk);

      // half duplex deferral
      full_duplex = 1'b0;
      mii_crs = 1'b1;
      f = n_bursts;
      add_frame(20, 1, 1);
      repeat (200) @(negedge clk);
      chk(n_bursts == f && mii_tx_en == 0, "R6", "held off by carrier", n_bursts - f, 0);
      mii_crs = 1'b0;
      wait_burst(); cmp_frame(10, "R6");

      // single collision inside the payload
      add_frame(40, 1, 1);
      hit_col(20); wait_burst();
      chk(bur_len == 20 + JAM, "R7", "collided burst length", bur_len, 20 + JAM);
      f = 1;
      for (int i = 20; i < 20 + JAM; i++) if (bur[i] !== 4'h5) f = 0;
      chk(f == 1, "R7", "jam nibbles", f, 1);
      wait_burst(); cmp_frame(11, "R7");
      chk(bur_gap <= bo_bound(1) && bur_gap >= IFG, "R8", "retry gap k=1", bur_gap, bo_bound(1));

      // three collisions then success
      add_frame(30, 0, 1);
      for (int k = 1; k <= 3; k++) begin
         hit_col(10); wait_burst();
         chk(bur_len == 10 + JAM, "R7", "collided burst", bur_len, 10 + JAM);
         if (k > 1) chk(bur_gap <= bo_bound(k - 1), "R8", "retry gap", bur_gap, bo_bound(k - 1));
      end
      wait_burst(); cmp_frame(12, "R7");
      chk(bur_gap <= bo_bound(3), "R8", "retry gap k=3", bur_gap, bo_bound(3));

      // excessive collisions drop the frame
      d0 = n_done;
      add_frame(20, 1, 1);
      add_frame(30, 1, 1);
      for (int k = 1; k <= MAXA; k++) begin
         hit_col(4); wait_burst();
         if (k > 1) chk(bur_gap <= bo_bound(k - 1), "R8", "retry gap long run", bur_gap, bo_bound(k - 1));
      end
      wait_burst(); cmp_frame(14, "R9");
      chk(n_drop == 1, "R9", "drop pulses", n_drop, 1);
      repeat (3) @(negedge clk);
      chk(n_done == d0 + 1, "R9", "only next frame completes", n_done - d0, 1);

      repeat (40) @(negedge clk);
      finish_run();
   end

endmodule